// File: doc/BRIEF.md
# Per-Line Black-Level and Gain Calibration Controller

This block closes two slow digital control loops around one channel of a video digitiser. Once per video line, while the sync strobe is active, the converter sees a fixed internal reference level (one sixteenth of the external reference) in place of picture content. The controller averages the converted reference, compares it with a programmed 7-bit coarse target and nudges a coarse gain code one step in the direction that pulls the next line's reference reading toward the target. Later in the same line, while the clamp pulse is high, it averages the converted black level, compares it with a clamp target taken from an 8-bit offset setting in half-LSB steps around code 0, and moves a signed offset correction code by a fraction of the measured error. This pulls a large initial offset in within roughly ten lines.

The gain and offset codes drive the analog gain and offset DACs outside this block. A separate flag marks each output sample that was converted during sync, so downstream logic can discard it as not valid video. The converter delivers each sample one clock after the input it converts, and the controller aligns all of its windows to that latency.

Top module: `line_calib_ctrl`

## Requirements
- R1: Sync is active when `sync_in` differs from `sync_pol`: with `sync_pol`=0 sync is active HIGH, with `sync_pol`=1 it is active LOW.
- R2: `video_invalid` is 1 in the clock cycle that follows every cycle in which sync was active, and 0 otherwise. This matches the converter's one-cycle latency.
- R3: A measurement window is the delayed sync (or clamp) interval. Its result is the sum of its first 4 samples divided by 4, with a sample that has `smp_ovf`=1 counted as 256. A window with fewer than 4 samples changes no code.
- R4: After each complete sync window, `gain_code` is reduced by 1 if the average exceeds the target by more than 1 LSB, increased by 1 if it is below the target by more than 1 LSB, and left unchanged otherwise.
- R5: The coarse target used in R4 is `coarse_tgt` limited to the range 32 to 99.
- R6: `gain_code` resets to 128 and saturates at 0 and 255 without wrapping.
- R7: The clamp target in half-LSB units is `offset_reg` minus 127, so 127 means code 0, 0 means -63.5 and 255 means +64. The measured level is twice the clamp window average, and the error is measured minus target. An error of magnitude 2 or less leaves `offs_code` unchanged.
- R8: Otherwise `offs_code` decreases by the error arithmetically shifted right by 1 (at least one unit in the error's sign). It saturates at -512 and +511 and resets to 0.
- R9: A clamp window is formed only while `clamp_in` is 1 and sync is not active. A clamp pulse that lies wholly inside sync does not change `offs_code`.
- R10: `gain_code` and `offs_code` change only in the cycle after a window completes and hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_code | input | 8 | Converted sample, straight binary |
| smp_ovf | input | 1 | Sample is above full scale |
| sync_in | input | 1 | Line sync strobe |
| sync_pol | input | 1 | Sync polarity select (0 = active HIGH) |
| clamp_in | input | 1 | Clamp pulse, active HIGH |
| coarse_tgt | input | 7 | Coarse gain target code |
| offset_reg | input | 8 | Clamp level setting, half-LSB steps |
| gain_code | output | 8 | Coarse gain control code |
| offs_code | output | 10 | Signed offset correction, half-LSB units |
| video_invalid | output | 1 | Current sample is not valid video |

## Verification
On every cycle, the assertions check that the invalid flag follows the sync strobe after one clock, and that a falling window edge yields a completion pulse. They also check that neither code moves without a completed window, that gain moves by at most one step per window, and that gain never wraps between its limits. Only the bench scenarios can show the loop arithmetic in use: the averaging with overflow, the dead bands, the target limits, the signed half-LSB error shift, the saturation values, the short-window rejection and the suppression of a clamp pulse hidden inside sync. The bench checks each of these against values it computes from the requirements.

// File: rtl/calib_pkg.sv
package calib_pkg;

    localparam int SMP_W = 8;
    localparam int VAL_W = SMP_W + 1;

    typedef logic [VAL_W-1:0] meas_t;

    typedef enum logic [1:0] {
        IN_BAND   = 2'd0,
        MEAS_LOW  = 2'd1,
        MEAS_HIGH = 2'd2
    } meas_dir_e;

    function automatic meas_dir_e judge(input int meas, input int tgt, input int band);
        if (meas > tgt + band) return MEAS_HIGH;
        if (meas < tgt - band) return MEAS_LOW;
        return IN_BAND;
    endfunction

endpackage

// File: rtl/win_avg.sv
module win_avg #(
    parameter int VAL_W    = 9,
    parameter int AVG_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_i,
    input  logic [VAL_W-1:0] val_i,
    output logic             done_o,
    output logic             full_o,
    output logic [VAL_W-1:0] avg_o
);
    localparam int N     = 1 << AVG_LOG2;
    localparam int CNT_W = AVG_LOG2 + 1;
    localparam int SUM_W = VAL_W + AVG_LOG2;

    typedef struct packed {
        logic             win;
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] sum;
        logic             done;
        logic             full;
        logic [VAL_W-1:0] avg;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.win  = win_i;
        st_d.done = 1'b0;
        if (st_q.win && !win_i) begin
            st_d.done = 1'b1;
            st_d.full = (st_q.cnt == CNT_W'(N));
            st_d.avg  = VAL_W'(st_q.sum >> AVG_LOG2);
            st_d.cnt  = '0;
            st_d.sum  = '0;
        end else if (win_i && (st_q.cnt != CNT_W'(N))) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.sum = st_q.sum + SUM_W'(val_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign full_o = st_q.full;
    assign avg_o  = st_q.avg;

    // R3
    win_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_i && st_q.win) |=> done_o);

endmodule

// File: rtl/gain_step.sv
module gain_step
    import calib_pkg::*;
#(
    parameter int GW     = 8,
    parameter int TGT_W  = 7,
    parameter int TGT_LO = 32,
    parameter int TGT_HI = 99,
    parameter int BAND   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic          full_i,
    input  meas_t         avg_i,
    input  logic [TGT_W-1:0] tgt_i,
    output logic [GW-1:0] gain_o
);
    localparam logic [GW-1:0] GMAX  = {GW{1'b1}};
    localparam logic [GW-1:0] GRST  = GW'(1) << (GW - 1);

    typedef struct packed {
        logic [GW-1:0] gain;
    } st_t;

    st_t       st_q, st_d;
    int        tgt_c;
    meas_dir_e dir;

    always_comb begin
        tgt_c = int'(tgt_i);
        if (tgt_c < TGT_LO) tgt_c = TGT_LO;
        if (tgt_c > TGT_HI) tgt_c = TGT_HI;
        dir  = judge(int'(avg_i), tgt_c, BAND);
        st_d = st_q;
        if (done_i && full_i) begin
            if (dir == MEAS_HIGH && st_q.gain != '0)
                st_d.gain = st_q.gain - 1'b1;
            else if (dir == MEAS_LOW && st_q.gain != GMAX)
                st_d.gain = st_q.gain + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.gain <= GRST;
        else        st_q      <= st_d;
    end

    assign gain_o = st_q.gain;

    // R4
    gain_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (gain_o == $past(gain_o) || gain_o == $past(gain_o) + 1'b1
                    || gain_o == $past(gain_o) - 1'b1));

    // R6
    gain_no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o == GMAX) |=> (gain_o != '0));

    // R6
    gain_no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o == '0) |=> (gain_o != GMAX));

    // R10
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(gain_o));

endmodule

// File: rtl/offs_step.sv
module offs_step
    import calib_pkg::*;
#(
    parameter int OW        = 10,
    parameter int REG_W     = 8,
    parameter int ZERO_CODE = 127,
    parameter int KSH       = 1,
    parameter int BAND2     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic                 full_i,
    input  meas_t                avg_i,
    input  logic [REG_W-1:0]     reg_i,
    output logic signed [OW-1:0] offs_o
);
    localparam int OMAX = (1 << (OW - 1)) - 1;
    localparam int OMIN = -(1 << (OW - 1));

    typedef struct packed {
        logic signed [OW-1:0] offs;
    } st_t;

    st_t       st_q, st_d;
    int        meas2, tgt2, err, delta, nxt;
    meas_dir_e dir;

    always_comb begin
        meas2 = 2 * int'(avg_i);
        tgt2  = int'(reg_i) - ZERO_CODE;
        err   = meas2 - tgt2;
        dir   = judge(meas2, tgt2, BAND2);
        delta = err >>> KSH;
        if (delta == 0) delta = (err > 0) ? 1 : -1;
        nxt   = int'(st_q.offs) - delta;
        if (nxt > OMAX) nxt = OMAX;
        if (nxt < OMIN) nxt = OMIN;
        st_d  = st_q;
        if (done_i && full_i && dir != IN_BAND)
            st_d.offs = OW'(nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign offs_o = st_q.offs;

    // R10
    offs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(offs_o));

endmodule

// File: rtl/line_calib_ctrl.sv
module line_calib_ctrl
    import calib_pkg::*;
#(
    parameter int GAIN_W   = 8,
    parameter int OFFS_W   = 10,
    parameter int AVG_LOG2 = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               smp_code,
    input  logic                     smp_ovf,
    input  logic                     sync_in,
    input  logic                     sync_pol,
    input  logic                     clamp_in,
    input  logic [6:0]               coarse_tgt,
    input  logic [7:0]               offset_reg,
    output logic [GAIN_W-1:0]        gain_code,
    output logic signed [OFFS_W-1:0] offs_code,
    output logic                     video_invalid
);
    typedef struct packed {
        logic sync_dly;
        logic clamp_dly;
    } st_t;

    st_t   st_q, st_d;
    logic  sync_act, clamp_act;
    meas_t val;
    logic  g_done, g_full, c_done, c_full;
    meas_t g_avg, c_avg;

    always_comb begin
        sync_act       = sync_in ^ sync_pol;
        clamp_act      = clamp_in & ~sync_act;
        val            = smp_ovf ? meas_t'(256) : meas_t'(smp_code);
        st_d.sync_dly  = sync_act;
        st_d.clamp_dly = clamp_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign video_invalid = st_q.sync_dly;

    win_avg #(.VAL_W(VAL_W), .AVG_LOG2(AVG_LOG2)) u_sync_avg (
        .clk(clk), .rst_n(rst_n), .win_i(st_q.sync_dly), .val_i(val),
        .done_o(g_done), .full_o(g_full), .avg_o(g_avg));

    win_avg #(.VAL_W(VAL_W), .AVG_LOG2(AVG_LOG2)) u_clamp_avg (
        .clk(clk), .rst_n(rst_n), .win_i(st_q.clamp_dly), .val_i(val),
        .done_o(c_done), .full_o(c_full), .avg_o(c_avg));

    gain_step #(.GW(GAIN_W), .TGT_W(7)) u_gain (
        .clk(clk), .rst_n(rst_n), .done_i(g_done), .full_i(g_full),
        .avg_i(g_avg), .tgt_i(coarse_tgt), .gain_o(gain_code));

    offs_step #(.OW(OFFS_W), .REG_W(8)) u_offs (
        .clk(clk), .rst_n(rst_n), .done_i(c_done), .full_i(c_full),
        .avg_i(c_avg), .reg_i(offset_reg), .offs_o(offs_code));

    // R2
    invalid_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in != sync_pol) |=> video_invalid);

    // R2
    invalid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in == sync_pol) |=> !video_invalid);

endmodule

// File: tb/sim_line_calib_ctrl.sv
module sim_line_calib_ctrl;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        smp_code = '0;
    logic              smp_ovf = 1'b0;
    logic              sync_in = 1'b0;
    logic              sync_pol = 1'b0;
    logic              clamp_in = 1'b0;
    logic [6:0]        coarse_tgt = 7'd32;
    logic [7:0]        offset_reg = 8'd127;
    logic [7:0]        gain_code;
    logic signed [9:0] offs_code;
    logic              video_invalid;

    int checks = 0;
    int failures = 0;
    int m_gain = 128;
    int m_offs = 0;

    always #5 clk = ~clk;

    line_calib_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .smp_code(smp_code), .smp_ovf(smp_ovf),
        .sync_in(sync_in), .sync_pol(sync_pol), .clamp_in(clamp_in),
        .coarse_tgt(coarse_tgt), .offset_reg(offset_reg),
        .gain_code(gain_code), .offs_code(offs_code), .video_invalid(video_invalid));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int clip_tgt(input int t);
        if (t < 32) return 32;
        if (t > 99) return 99;
        return t;
    endfunction

    // model of R3..R9 from the requirement text
    task automatic model(input int slen, input int clen, input int v);
        int t, e, d;
        if (slen >= 4) begin
            t = clip_tgt(int'(coarse_tgt));
            if (v > t + 1 && m_gain > 0) m_gain--;
            else if (v < t - 1 && m_gain < 255) m_gain++;
        end
        if (clen >= 4) begin
            e = 2 * v - (int'(offset_reg) - 127);
            if (e > 2 || e < -2) begin
                d = e >>> 1;
                if (d == 0) d = (e > 0) ? 1 : -1;
                m_offs = m_offs - d;
                if (m_offs > 511) m_offs = 511;
                if (m_offs < -512) m_offs = -512;
            end
        end
    endtask

    task automatic run_line(input int slen, input int clen, input int code,
                            input bit ovf, input bit overlap);
        smp_code = 8'(code);
        smp_ovf  = ovf;
        @(negedge clk);
        sync_in  = ~sync_pol;
        if (overlap) clamp_in = 1'b1;
        idle(slen);
        sync_in  = sync_pol;
        clamp_in = 1'b0;
        idle(3);
        if (!overlap && clen > 0) begin
            clamp_in = 1'b1;
            idle(clen);
            clamp_in = 1'b0;
        end
        idle(8);
        model(slen, overlap ? 0 : clen, ovf ? 256 : code);
    endtask

    task automatic t_reset;
        chk("R6 gain reset", int'(gain_code), 128);
        chk("R8 offs reset", int'(offs_code), 0);
        chk("R2 flag reset", int'(video_invalid), 0);
    endtask

    task automatic t_flag;
        sync_pol = 1'b0; sync_in = 1'b1; smp_code = 8'd60;
        @(negedge clk);
        chk("R1 R2 active-high flag", int'(video_invalid), 1);
        sync_in = 1'b0;
        @(negedge clk);
        chk("R2 flag clears", int'(video_invalid), 0);
        sync_pol = 1'b1; sync_in = 1'b1;
        @(negedge clk);
        chk("R1 high level inactive when pol=1", int'(video_invalid), 0);
        sync_in = 1'b0;
        @(negedge clk);
        chk("R1 low level active when pol=1", int'(video_invalid), 1);
        sync_in = 1'b1;
        idle(10);
        chk("R3 one-sample window leaves gain", int'(gain_code), 128);
        sync_pol = 1'b0; sync_in = 1'b0;
        idle(4);
    endtask

    task automatic t_gain;
        coarse_tgt = 7'd50;
        run_line(8, 0, 60, 0, 0);
        chk("R4 high reading lowers gain", int'(gain_code), m_gain);
        run_line(8, 0, 51, 0, 0);
        chk("R4 dead band holds gain", int'(gain_code), m_gain);
        run_line(8, 0, 40, 0, 0);
        chk("R4 low reading raises gain", int'(gain_code), m_gain);
        run_line(3, 0, 10, 0, 0);
        chk("R3 short window ignored", int'(gain_code), m_gain);
        sync_pol = 1'b1; sync_in = 1'b1;
        run_line(6, 0, 90, 0, 0);
        chk("R1 active-low window lowers gain", int'(gain_code), m_gain);
        sync_pol = 1'b0; sync_in = 1'b0;
        coarse_tgt = 7'd10;
        run_line(8, 0, 31, 0, 0);
        chk("R5 low clip dead band", int'(gain_code), m_gain);
        run_line(8, 0, 30, 0, 0);
        chk("R5 low clip raises", int'(gain_code), m_gain);
        coarse_tgt = 7'd120;
        run_line(8, 0, 101, 0, 0);
        chk("R5 high clip lowers", int'(gain_code), m_gain);
        coarse_tgt = 7'd99;
        run_line(8, 0, 0, 1, 0);
        chk("R3 overflow counts as 256", int'(gain_code), m_gain);
    endtask

    task automatic t_gain_sat;
        coarse_tgt = 7'd32;
        for (int i = 0; i < 135; i++) run_line(4, 0, 200, 0, 0);
        chk("R6 gain floor", int'(gain_code), 0);
        chk("R6 model floor", m_gain, 0);
        for (int i = 0; i < 260; i++) run_line(4, 0, 0, 0, 0);
        chk("R6 gain ceiling", int'(gain_code), 255);
    endtask

    task automatic t_offs;
        offset_reg = 8'd127;
        run_line(0, 8, 5, 0, 0);
        chk("R7 R8 error 10 step", int'(offs_code), m_offs);
        chk("R8 expected -5", m_offs, -5);
        run_line(0, 8, 1, 0, 0);
        chk("R7 dead band holds", int'(offs_code), m_offs);
        offset_reg = 8'd255;
        run_line(0, 8, 0, 0, 0);
        chk("R7 +64 target", int'(offs_code), m_offs);
        offset_reg = 8'd0;
        run_line(0, 8, 0, 0, 0);
        chk("R7 -63.5 target", int'(offs_code), m_offs);
        offset_reg = 8'd130;
        run_line(0, 8, 0, 0, 0);
        chk("R8 negative odd error", int'(offs_code), m_offs);
        run_line(0, 3, 90, 0, 0);
        chk("R3 short clamp ignored", int'(offs_code), m_offs);
        run_line(6, 8, 90, 0, 1);
        chk("R9 clamp inside sync ignored", int'(offs_code), m_offs);
        offset_reg = 8'd0;
        for (int i = 0; i < 3; i++) run_line(0, 8, 255, 0, 0);
        chk("R8 floor", int'(offs_code), -512);
        offset_reg = 8'd255;
        for (int i = 0; i < 18; i++) run_line(0, 8, 0, 0, 0);
        chk("R8 ceiling", int'(offs_code), 511);
        chk("R10 gain untouched by clamp", int'(gain_code), m_gain);
    endtask

    initial begin
        idle(3);
        t_reset;
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_flag;
        t_gain;
        t_gain_sat;
        t_offs;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_900_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule